// File: doc/BRIEF.md
# Nested Trap State Stack

This block keeps one saved copy of the processor state for each nesting level of a trap-capable core. When a trap is accepted, it packs the live condition codes, address-space identifier, processor-state and window-pointer fields into one saved word. It stores that word with the interrupted PC, next-PC and trap type in the slot of the current level. It then forces the supervisor processor-state bits, builds the trap vector from the trap base and the trap type, and moves one level deeper. The trap vector becomes the new PC.

Returning from a trap comes in two forms. A retry resumes at the saved PC and next-PC. A done resumes at the saved next-PC and continues sequentially from there. Both forms unpack the saved word of the innermost level back onto the state outputs and move one level up. A trap that arrives when every level is already in use is not saved. It raises a sticky error flag instead. The last available level also enters the reduced-function (RED) processor state.

The outputs are registered. The `state_load` pulse marks the cycle in which the surrounding core should adopt the new PC, next-PC and state fields.

Top module: `trap_state_stack`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is zero. This includes `tl_out`, `state_load` and `error_state`.
- R2: An accepted trap stores this 40-bit word at the current level: condition codes in [39:32], address-space identifier in [31:24], zeros in [23:20], processor state in [19:8] and window pointer in [7:0]. While the level is non-zero, `saved_word` shows the word of the innermost level (level minus 1).
- R3: After an accepted trap, `pstate_out` is 12'h015: bit 4 (FP enable), bit 2 (privileged) and bit 0 (alternate globals). When the trap was taken at level MAX_TL-1, bit 5 (RED) is set as well, which gives 12'h035.
- R4: After an accepted trap, `tbr_out` keeps bits [PC_W-1:15] of `tba_base`. Bit 14 is 1 only if the level before the trap was above 1. Bits [13:5] hold the trap type and bits [4:0] are zero.
- R5: After an accepted trap, `pc_out` equals `tbr_out`, `npc_out` equals `pc_out`+4, and `state_load` pulses for one cycle. Each of these outputs is registered and shows its value in the cycle after the request.
- R6: An accepted trap raises `tl_out` by one. `tl_out` never exceeds MAX_TL.
- R7: A trap requested while `tl_out` equals MAX_TL saves nothing, leaves every other output unchanged and produces no `state_load`. It sets `error_state`, which stays set until reset.
- R8: A done return sets `pc_out` to the saved next-PC and `npc_out` to the saved next-PC+4. It lowers `tl_out` by one and pulses `state_load`.
- R9: A retry return sets `pc_out` to the saved PC and `npc_out` to the saved next-PC. It lowers `tl_out` by one and pulses `state_load`.
- R10: Both return forms restore `ccr_out`, `asi_out`, `pstate_out` and `cwp_out` from the fields of the innermost saved word.
- R11: A return requested at level 0 is ignored: no `state_load`, and all outputs hold their values.
- R12: When requests coincide, a trap takes precedence over both return forms, and a retry takes precedence over a done.
- R13: `tt_out` shows the trap type saved at the innermost level, or zero at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Type of the requested trap |
| retry_req | input | 1 | Return, resuming at the saved PC |
| done_req | input | 1 | Return, resuming after the saved instruction |
| tba_base | input | PC_W | Trap base; upper bits [PC_W-1:15] are used |
| pc_in | input | PC_W | Live PC |
| npc_in | input | PC_W | Live next-PC |
| ccr_in | input | 8 | Live condition codes |
| asi_in | input | 8 | Live address-space identifier |
| pstate_in | input | 12 | Live processor state |
| cwp_in | input | 8 | Live window pointer |
| pc_out | output | PC_W | New PC |
| npc_out | output | PC_W | New next-PC |
| ccr_out | output | 8 | Restored condition codes |
| asi_out | output | 8 | Restored address-space identifier |
| pstate_out | output | 12 | Forced or restored processor state |
| cwp_out | output | 8 | Restored window pointer |
| tbr_out | output | PC_W | Trap base with the vector offset |
| tl_out | output | $clog2(MAX_TL+1) | Current trap level |
| tt_out | output | 9 | Trap type at the innermost level |
| saved_word | output | 40 | Saved state word at the innermost level |
| state_load | output | 1 | One-cycle pulse: adopt the new values |
| error_state | output | 1 | Sticky: a trap arrived with all levels in use |

## Verification
The assertions assume that the request inputs are known in every cycle after reset. They also assume that a coincident trap and return is resolved only by the priority in R12. They make no assumption about the live state inputs. The stimulus changes the live fields and the trap base every cycle. It drives the level to full and into the error case. It issues returns at level 0 and overlaps requests on purpose. Beyond that, the driven request patterns only decide how often each case occurs.

// File: rtl/trap_state_stack_pkg.sv
package trap_state_stack_pkg;
    localparam int CCR_W  = 8;
    localparam int ASI_W  = 8;
    localparam int PST_W  = 12;
    localparam int CWP_W  = 8;
    localparam int TT_W   = 9;
    localparam int PAD_W  = 4;
    localparam int WORD_W = CCR_W + ASI_W + PAD_W + PST_W + CWP_W;

    // field positions inside the saved word
    localparam int CWP_LSB = 0;
    localparam int PST_LSB = CWP_LSB + CWP_W;
    localparam int ASI_LSB = PST_LSB + PST_W + PAD_W;
    localparam int CCR_LSB = ASI_LSB + ASI_W;

    // trap base layout
    localparam int VEC_LOW_W = 15;
    localparam int TT_LSB    = 5;

    // processor-state bits
    localparam logic [PST_W-1:0] PST_FORCED = 12'h015;
    localparam logic [PST_W-1:0] PST_RED    = 12'h020;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_TRAP,
        OP_FULL,
        OP_RETRY,
        OP_DONE
    } stack_op_e;

    function automatic logic [WORD_W-1:0] pack_frame(
        input logic [CCR_W-1:0] ccr,
        input logic [ASI_W-1:0] asi,
        input logic [PST_W-1:0] pst,
        input logic [CWP_W-1:0] cwp
    );
        return {ccr, asi, {PAD_W{1'b0}}, pst, cwp};
    endfunction
endpackage

// File: rtl/trap_frame_store.sv
module trap_frame_store
    import trap_state_stack_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int DEPTH = 5,
    parameter int AW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_lvl,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [PC_W-1:0]   wr_npc,
    input  logic [TT_W-1:0]   wr_tt,
    input  logic [AW-1:0]     rd_lvl,
    output logic [WORD_W-1:0] rd_word,
    output logic [PC_W-1:0]   rd_pc,
    output logic [PC_W-1:0]   rd_npc,
    output logic [TT_W-1:0]   rd_tt
);
    logic [WORD_W-1:0] word_a [DEPTH];
    logic [PC_W-1:0]   pc_a   [DEPTH];
    logic [PC_W-1:0]   npc_a  [DEPTH];
    logic [TT_W-1:0]   tt_a   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        logic [WORD_W-1:0] word_q;
        logic [PC_W-1:0]   pc_q;
        logic [PC_W-1:0]   npc_q;
        logic [TT_W-1:0]   tt_q;
        logic              hit;

        assign hit = wr_en && (wr_lvl == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
                pc_q   <= '0;
                npc_q  <= '0;
                tt_q   <= '0;
            end else if (hit) begin
                word_q <= wr_word;
                pc_q   <= wr_pc;
                npc_q  <= wr_npc;
                tt_q   <= wr_tt;
            end
        end

        assign word_a[g] = word_q;
        assign pc_a[g]   = pc_q;
        assign npc_a[g]  = npc_q;
        assign tt_a[g]   = tt_q;
    end

    always_comb begin
        rd_word = '0;
        rd_pc   = '0;
        rd_npc  = '0;
        rd_tt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_lvl == AW'(i)) begin
                rd_word = word_a[i];
                rd_pc   = pc_a[i];
                rd_npc  = npc_a[i];
                rd_tt   = tt_a[i];
            end
        end
    end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
    import trap_state_stack_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input  logic [TL_W-1:0]  tl,
    input  logic [TT_W-1:0]  tt,
    input  logic [PC_W-1:0]  tba,
    output logic [PC_W-1:0]  vec,
    output logic [PST_W-1:0] pst_new
);
    logic nested;
    logic last_lvl;

    assign nested   = tl > TL_W'(1);
    assign last_lvl = tl == TL_W'(MAX_TL - 1);
    assign vec      = {tba[PC_W-1:VEC_LOW_W], nested, tt, {TT_LSB{1'b0}}};
    assign pst_new  = PST_FORCED | (last_lvl ? PST_RED : '0);
endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack
    import trap_state_stack_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int MAX_TL = 5,
    localparam int TL_W  = $clog2(MAX_TL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [TT_W-1:0]   trap_type,
    input  logic              retry_req,
    input  logic              done_req,
    input  logic [PC_W-1:0]   tba_base,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   npc_in,
    input  logic [CCR_W-1:0]  ccr_in,
    input  logic [ASI_W-1:0]  asi_in,
    input  logic [PST_W-1:0]  pstate_in,
    input  logic [CWP_W-1:0]  cwp_in,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   npc_out,
    output logic [CCR_W-1:0]  ccr_out,
    output logic [ASI_W-1:0]  asi_out,
    output logic [PST_W-1:0]  pstate_out,
    output logic [CWP_W-1:0]  cwp_out,
    output logic [PC_W-1:0]   tbr_out,
    output logic [TL_W-1:0]   tl_out,
    output logic [TT_W-1:0]   tt_out,
    output logic [WORD_W-1:0] saved_word,
    output logic              state_load,
    output logic              error_state
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
        logic [PC_W-1:0]  tbr;
        logic [CCR_W-1:0] ccr;
        logic [ASI_W-1:0] asi;
        logic [PST_W-1:0] pst;
        logic [CWP_W-1:0] cwp;
        logic [TL_W-1:0]  tl;
        logic             load;
        logic             err;
    } stack_regs_t;

    stack_regs_t r_q, r_d;
    stack_op_e   op;

    logic              empty;
    logic              full;
    logic [TL_W-1:0]   rd_lvl;
    logic [WORD_W-1:0] rd_word;
    logic [PC_W-1:0]   rd_pc;
    logic [PC_W-1:0]   rd_npc;
    logic [TT_W-1:0]   rd_tt;
    logic [PC_W-1:0]   vec;
    logic [PST_W-1:0]  pst_new;

    assign empty  = r_q.tl == '0;
    assign full   = r_q.tl == TL_W'(MAX_TL);
    assign rd_lvl = empty ? '0 : r_q.tl - TL_W'(1);

    trap_frame_store #(
        .PC_W (PC_W),
        .DEPTH(MAX_TL),
        .AW   (TL_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (op == OP_TRAP),
        .wr_lvl (r_q.tl),
        .wr_word(pack_frame(ccr_in, asi_in, pstate_in, cwp_in)),
        .wr_pc  (pc_in),
        .wr_npc (npc_in),
        .wr_tt  (trap_type),
        .rd_lvl (rd_lvl),
        .rd_word(rd_word),
        .rd_pc  (rd_pc),
        .rd_npc (rd_npc),
        .rd_tt  (rd_tt)
    );

    trap_vector_gen #(
        .PC_W  (PC_W),
        .MAX_TL(MAX_TL),
        .TL_W  (TL_W)
    ) u_vec (
        .tl     (r_q.tl),
        .tt     (trap_type),
        .tba    (tba_base),
        .vec    (vec),
        .pst_new(pst_new)
    );

    always_comb begin
        if (trap_req)                op = full ? OP_FULL : OP_TRAP;
        else if (retry_req && !empty) op = OP_RETRY;
        else if (done_req && !empty)  op = OP_DONE;
        else                          op = OP_IDLE;

        r_d      = r_q;
        r_d.load = 1'b0;
        unique case (op)
            OP_TRAP: begin
                r_d.tbr  = vec;
                r_d.pc   = vec;
                r_d.npc  = vec + PC_W'(4);
                r_d.pst  = pst_new;
                r_d.tl   = r_q.tl + TL_W'(1);
                r_d.load = 1'b1;
            end
            OP_FULL: begin
                r_d.err = 1'b1;
            end
            OP_RETRY, OP_DONE: begin
                r_d.pc   = (op == OP_RETRY) ? rd_pc : rd_npc;
                r_d.npc  = (op == OP_RETRY) ? rd_npc : rd_npc + PC_W'(4);
                r_d.ccr  = rd_word[CCR_LSB +: CCR_W];
                r_d.asi  = rd_word[ASI_LSB +: ASI_W];
                r_d.pst  = rd_word[PST_LSB +: PST_W];
                r_d.cwp  = rd_word[CWP_LSB +: CWP_W];
                r_d.tl   = r_q.tl - TL_W'(1);
                r_d.load = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pc_out      = r_q.pc;
    assign npc_out     = r_q.npc;
    assign ccr_out     = r_q.ccr;
    assign asi_out     = r_q.asi;
    assign pstate_out  = r_q.pst;
    assign cwp_out     = r_q.cwp;
    assign tbr_out     = r_q.tbr;
    assign tl_out      = r_q.tl;
    assign tt_out      = empty ? '0 : rd_tt;
    assign saved_word  = empty ? '0 : rd_word;
    assign state_load  = r_q.load;
    assign error_state = r_q.err;
endmodule

module trap_state_stack_chk #(
    parameter int PC_W   = 64,
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic            retry_req,
    input logic            done_req,
    input logic [PC_W-1:0] pc_out,
    input logic [PC_W-1:0] npc_out,
    input logic [11:0]     pstate_out,
    input logic [TL_W-1:0] tl_out,
    input logic            state_load,
    input logic            error_state
);
    a_r6_tl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tl_out <= TL_W'(MAX_TL));

    a_r6_trap_inc: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && tl_out < TL_W'(MAX_TL) |=> tl_out == $past(tl_out) + TL_W'(1));

    a_r5_npc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && tl_out < TL_W'(MAX_TL) |=> state_load && npc_out == pc_out + PC_W'(4));

    a_r3_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && tl_out < TL_W'(MAX_TL) |=> pstate_out[4] && pstate_out[2] && pstate_out[0]);

    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && tl_out == TL_W'(MAX_TL) |=> error_state && !state_load && tl_out == TL_W'(MAX_TL));

    a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error_state |=> error_state);

    a_r11_empty_return: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req && tl_out == '0 |=> !state_load && tl_out == '0);

    a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req && (retry_req || done_req) && tl_out != '0
        |=> state_load && tl_out == $past(tl_out) - TL_W'(1));
endmodule

bind trap_state_stack trap_state_stack_chk #(
    .PC_W  (PC_W),
    .MAX_TL(MAX_TL),
    .TL_W  (TL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .retry_req  (retry_req),
    .done_req   (done_req),
    .pc_out     (pc_out),
    .npc_out    (npc_out),
    .pstate_out (pstate_out),
    .tl_out     (tl_out),
    .state_load (state_load),
    .error_state(error_state)
);

// File: tb/trap_state_stack_tb.sv
module trap_state_stack_tb;
    localparam int PC_W = 64;
    localparam int MAXL = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 0, retry_req = 0, done_req = 0;
    logic [8:0]      trap_type = '0;
    logic [PC_W-1:0] tba_base = '0, pc_in = '0, npc_in = '0;
    logic [7:0]      ccr_in = '0, asi_in = '0, cwp_in = '0;
    logic [11:0]     pstate_in = '0;
    logic [PC_W-1:0] pc_out, npc_out, tbr_out;
    logic [7:0]      ccr_out, asi_out, cwp_out;
    logic [11:0]     pstate_out;
    logic [2:0]      tl_out;
    logic [8:0]      tt_out;
    logic [39:0]     saved_word;
    logic            state_load, error_state;

    always #5 clk = ~clk;

    trap_state_stack u_dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .retry_req(retry_req), .done_req(done_req), .tba_base(tba_base),
        .pc_in(pc_in), .npc_in(npc_in), .ccr_in(ccr_in), .asi_in(asi_in),
        .pstate_in(pstate_in), .cwp_in(cwp_in), .pc_out(pc_out), .npc_out(npc_out),
        .ccr_out(ccr_out), .asi_out(asi_out), .pstate_out(pstate_out),
        .cwp_out(cwp_out), .tbr_out(tbr_out), .tl_out(tl_out), .tt_out(tt_out),
        .saved_word(saved_word), .state_load(state_load), .error_state(error_state)
    );

    // reference model state
    int              m_tl = 0;
    logic [39:0]     m_word [MAXL];
    logic [PC_W-1:0] m_tpc  [MAXL];
    logic [PC_W-1:0] m_tnpc [MAXL];
    logic [8:0]      m_tt   [MAXL];
    logic [PC_W-1:0] m_pc = '0, m_npc = '0, m_tbr = '0;
    logic [7:0]      m_ccr = '0, m_asi = '0, m_cwp = '0;
    logic [11:0]     m_pst = '0;
    logic            m_load = 0, m_err = 0;

    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [39:0] w;
        logic [8:0]  t;
        w = (m_tl > 0) ? m_word[m_tl-1] : '0;
        t = (m_tl > 0) ? m_tt[m_tl-1] : '0;
        check(tag, "pc", pc_out, m_pc);
        check(tag, "npc", npc_out, m_npc);
        check(tag, "tbr", tbr_out, m_tbr);
        check(tag, "ccr", 64'(ccr_out), 64'(m_ccr));
        check(tag, "asi", 64'(asi_out), 64'(m_asi));
        check(tag, "pstate", 64'(pstate_out), 64'(m_pst));
        check(tag, "cwp", 64'(cwp_out), 64'(m_cwp));
        check(tag, "tl", 64'(tl_out), 64'(m_tl));
        check(tag, "tt", 64'(tt_out), 64'(t));
        check(tag, "word", 64'(saved_word), 64'(w));
        check(tag, "load", 64'(state_load), 64'(m_load));
        check(tag, "err", 64'(error_state), 64'(m_err));
    endtask

    task automatic model_edge(output string tag);
        logic [PC_W-1:0] v;
        m_load = 0;
        if (trap_req) begin
            if (m_tl == MAXL) begin
                m_err = 1;
                tag = "R7";
            end else begin
                m_word[m_tl] = {ccr_in, asi_in, 4'h0, pstate_in, cwp_in};
                m_tpc[m_tl]  = pc_in;
                m_tnpc[m_tl] = npc_in;
                m_tt[m_tl]   = trap_type;
                v = {tba_base[PC_W-1:15], (m_tl > 1) ? 1'b1 : 1'b0, trap_type, 5'b0};
                m_tbr = v;
                m_pc  = v;
                m_npc = v + 64'd4;
                m_pst = 12'h015 | ((m_tl == MAXL - 1) ? 12'h020 : 12'h000);
                m_tl++;
                m_load = 1;
                tag = (retry_req || done_req) ? "R12" : "R5";
            end
        end else if ((retry_req || done_req) && m_tl > 0) begin
            m_tl--;
            if (retry_req) begin
                m_pc  = m_tpc[m_tl];
                m_npc = m_tnpc[m_tl];
                tag = done_req ? "R12" : "R9";
            end else begin
                m_pc  = m_tnpc[m_tl];
                m_npc = m_tnpc[m_tl] + 64'd4;
                tag = "R8";
            end
            m_ccr = m_word[m_tl][39:32];
            m_asi = m_word[m_tl][31:24];
            m_pst = m_word[m_tl][19:8];
            m_cwp = m_word[m_tl][7:0];
            m_load = 1;
        end else begin
            tag = (retry_req || done_req) ? "R11" : "R13";
        end
    endtask

    // drive at negedge, update model after posedge, compare at next negedge
    task automatic step(input bit t, input bit rt, input bit dn);
        string tag;
        trap_req  = t;
        retry_req = rt;
        done_req  = dn;
        @(posedge clk);
        model_edge(tag);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic set_live(input logic [31:0] s);
        ccr_in    = s[7:0];
        asi_in    = s[15:8];
        pstate_in = s[27:16];
        cwp_in    = s[31:24];
        pc_in     = {s, ~s};
        npc_in    = {s, ~s} + 64'd4;
        trap_type = s[20:12];
        tba_base  = {~s, s};
    endtask

    function automatic logic [31:0] next_lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        for (int i = 0; i < MAXL; i++) begin
            m_word[i] = '0; m_tpc[i] = '0; m_tnpc[i] = '0; m_tt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare_all("R1");

        // R11: returns at level 0
        step(0, 1, 0);
        step(0, 0, 1);

        // first trap with hand-computed values
        tba_base = 64'hFFFF_0000_0000_8000; trap_type = 9'h041;
        ccr_in = 8'hA5; asi_in = 8'h80; pstate_in = 12'h3C7; cwp_in = 8'h03;
        pc_in = 64'h1000; npc_in = 64'h1004;
        step(1, 0, 0);
        check("R5", "pc hand", pc_out, 64'hFFFF_0000_0000_8820);
        check("R5", "npc hand", npc_out, 64'hFFFF_0000_0000_8824);
        check("R2", "word hand", 64'(saved_word), 64'hA5_8003_C703);
        check("R13", "tt hand", 64'(tt_out), 64'h041);
        check("R3", "pstate hand", 64'(pstate_out), 64'h015);
        check("R6", "tl hand", 64'(tl_out), 64'd1);
        check("R4", "tbr bit14 at tl0", 64'(tbr_out[14]), 64'd0);

        set_live(32'h1111_2222);
        step(1, 0, 0);
        check("R4", "tbr bit14 at tl1", 64'(tbr_out[14]), 64'd0);
        set_live(32'h3333_4444);
        step(1, 0, 0);
        check("R4", "tbr bit14 at tl2", 64'(tbr_out[14]), 64'd1);
        set_live(32'h5555_6666);
        step(1, 0, 0);
        check("R3", "pstate below last", 64'(pstate_out), 64'h015);
        set_live(32'h7777_8888);
        step(1, 0, 0);
        check("R3", "pstate RED at last", 64'(pstate_out), 64'h035);
        check("R6", "tl full", 64'(tl_out), 64'd5);

        // R7: trap with every level in use
        set_live(32'h9999_AAAA);
        step(1, 0, 0);
        check("R7", "error set", 64'(error_state), 64'd1);
        check("R7", "tl held", 64'(tl_out), 64'd5);

        // returns
        step(0, 1, 0);
        check("R9", "retry pc", pc_out, {32'h7777_8888, ~32'h7777_8888});
        check("R10", "ccr restored", 64'(ccr_out), 64'h88);
        check("R10", "cwp restored", 64'(cwp_out), 64'h77);
        step(0, 0, 1);
        check("R8", "done pc", pc_out, {32'h5555_6666, ~32'h5555_6666} + 64'd4);
        check("R8", "done npc", npc_out, {32'h5555_6666, ~32'h5555_6666} + 64'd8);

        // R12: coincident requests
        set_live(32'hC0DE_F00D);
        step(1, 0, 1);
        check("R12", "trap wins tl", 64'(tl_out), 64'd4);
        step(0, 1, 1);
        check("R12", "retry wins pc", pc_out, {32'hC0DE_F00D, ~32'hC0DE_F00D});

        // pseudo-random mix
        for (int n = 0; n < 3000; n++) begin
            lfsr = next_lfsr(lfsr);
            set_live(lfsr ^ 32'(n));
            lfsr = next_lfsr(lfsr);
            step(lfsr[2:0] < 3'd3, lfsr[5:3] < 3'd3, lfsr[8:6] < 3'd4);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule